// File: doc/BRIEF.md
# Multi-Bank Aligned Clock Divider

This block takes one fast input clock and produces four banks of two outputs each. Every bank owns a single divider, so both outputs of a bank carry the same divided clock. Each bank picks its own ratio from the set 1, 2, 3, 4, 5, 6 and 8. Every ratio gives a 50% duty cycle. Odd ratios reach this by stretching the high phase with a register clocked on the falling edge. Every output transition lands on an edge of the input clock.

An active-low divider reset holds all banks. When it is released, every enabled output goes high on the same rising edge of the input clock, so the banks start in phase. Ratios are captured while the reset is low and take effect only at the next release. A configuration word is shifted in on a serial clock and copied into the working register when a load strobe rises. Each output can be gated low by its own enable bit, by a global enable, or by the load strobe being low. Gating changes only while the bank is in its low phase, so no shortened pulse reaches an output.

Top module: `clkDivFanout`

## Requirements
- R1: The 20-bit configuration word is shifted in MSB first on rising edges of `serClk`, with only the last 20 bits kept. It is copied to the working register on the first rising edge of `clkIn` after `loadEn` goes from low to high. Bits 19:17 hold the ratio code of bank 0, 16:14 bank 1, 13:11 bank 2 and 10:8 bank 3. Bit k (k = 0..7) of bits 7:0 enables output k, and output k belongs to bank k/2.
- R2: Ratio codes map as 000→1, 001→2, 010→3, 011→4, 100→5, 101→6 and 110→8. Code 111 divides by 1.
- R3: While `rstDivN` is low, all outputs are low. After a release, every enabled output goes high on the first rising edge of `clkIn` that samples `rstDivN` high.
- R4: A bank with ratio N is high for N input half-periods and low for the next N, repeating from the release edge. So the period is N input periods, with 50% duty for odd N as well.
- R5: Every output transition coincides with an edge of `clkIn`. Between edges the outputs are constant.
- R6: Both enabled outputs of a bank are identical at all times.
- R7: A ratio code loaded while the dividers run has no effect until the next release of `rstDivN`.
- R8: An output whose enable bit is 0 stays low.
- R9: While `oeGlobal` is low, all outputs are low.
- R10: While `loadEn` is low, all outputs are low.
- R11: Enabling or disabling an output changes it only during its bank's low phase. Every high pulse it produces is a full N half-periods long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to divide |
| rstDivN | input | 1 | Active-low divider reset; release starts all banks high together |
| oeGlobal | input | 1 | Global output enable, active high |
| loadEn | input | 1 | Load strobe; a rising edge latches the shifted word, and low disables all outputs |
| serClk | input | 1 | Serial configuration clock |
| serData | input | 1 | Serial configuration data, MSB first |
| outClk | output | 8 | Divided outputs; bits 2b and 2b+1 belong to bank b |

## Verification
The bench measures each output at three points in every input half-period. The middle point is compared against a pattern computed from the ratio and the half-period count since release. The outer points catch a design whose odd-ratio edges drift off the input clock edges, or whose duty cycle is off by one half-period. It toggles the global enable and the load strobe mid-run and measures the length of every high pulse, which exposes a gate that cuts a pulse short or starts one in the middle of a high phase. It also loads a new ratio while running, to catch a divider that switches ratio without a reset and loses alignment. It shifts extra leading bits to catch a shift register that keeps the wrong end of the stream.

// File: rtl/clkDivFanoutPkg.sv
`timescale 1ns/1ps
package clkDivFanoutPkg;
  parameter int NUM_BANKS     = 4;
  parameter int OUTS_PER_BANK = 2;
  parameter int CODE_W        = 3;
  parameter int MAX_RATIO     = 8;

  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK;
  localparam int CODES_W  = NUM_BANKS * CODE_W;
  localparam int CFG_W    = CODES_W + NUM_OUTS;
  localparam int CNT_W    = $clog2(MAX_RATIO);
  localparam int RATIO_W  = CNT_W + 1;

  // Strobes from the configuration control to the divider datapath.
  typedef struct packed {
    logic [CODES_W-1:0]  ratioCodes;
    logic [NUM_OUTS-1:0] outWant;
  } ctrlStrobes_t;

  // Ratio selected by a bank code; the unused code falls back to 1.
  function automatic logic [RATIO_W-1:0] codeToRatio(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(0): return RATIO_W'(1);
      CODE_W'(1): return RATIO_W'(2);
      CODE_W'(2): return RATIO_W'(3);
      CODE_W'(3): return RATIO_W'(4);
      CODE_W'(4): return RATIO_W'(5);
      CODE_W'(5): return RATIO_W'(6);
      CODE_W'(6): return RATIO_W'(8);
      default:    return RATIO_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/clkDivFanoutCtrl.sv
`timescale 1ns/1ps
module clkDivFanoutCtrl
  import clkDivFanoutPkg::*;
(
  input  logic         clkIn,
  input  logic         serClk,
  input  logic         serData,
  input  logic         loadEn,
  input  logic         oeGlobal,
  output ctrlStrobes_t strobes
);
  logic [CFG_W-1:0] shiftQ;
  logic [CFG_W-1:0] cfgQ;
  logic             loadEnQ;
  logic             outsAllowed;

  // R1: serial word enters at the LSB, so the first bit ends at the MSB.
  always_ff @(posedge serClk) begin
    shiftQ <= {shiftQ[CFG_W-2:0], serData};
  end

  // R1: copy on the rising edge of the load strobe seen by the input clock.
  always_ff @(posedge clkIn) begin
    loadEnQ <= loadEn;
    if (loadEn && !loadEnQ) begin
      cfgQ <= shiftQ;
    end
  end

  // R9, R10: both the global enable and the load strobe gate every output.
  assign outsAllowed        = oeGlobal & loadEn;
  assign strobes.ratioCodes = cfgQ[CFG_W-1 -: CODES_W];
  assign strobes.outWant    = cfgQ[NUM_OUTS-1:0] & {NUM_OUTS{outsAllowed}};
endmodule

// File: rtl/clkDivFanoutBank.sv
`timescale 1ns/1ps
module clkDivFanoutBank
  import clkDivFanoutPkg::*;
#(
  parameter int OUTS = OUTS_PER_BANK
) (
  input  logic              clkIn,
  input  logic              rstDivN,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [OUTS-1:0]   want,
  output logic [OUTS-1:0]   outClk,
  output logic [CODE_W-1:0] activeCode
);
  logic [CODE_W-1:0]  codeQ;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   cntNext;
  logic [CNT_W-1:0]   lastIdx;
  logic [CNT_W-1:0]   cfgLastIdx;
  logic [CNT_W-1:0]   hiLen;
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] cfgRatio;
  logic               phaseQ;
  logic               negQ;
  logic               runQ;
  logic               isDiv1;
  logic               isOdd;
  logic               bankOut;
  logic               bankLow;
  logic [OUTS-1:0]    enQ;

  assign ratio      = codeToRatio(codeQ);
  assign cfgRatio   = codeToRatio(cfgCode);
  assign lastIdx    = CNT_W'(ratio - RATIO_W'(1));
  assign cfgLastIdx = CNT_W'(cfgRatio - RATIO_W'(1));
  assign hiLen      = CNT_W'(ratio >> 1);
  assign isDiv1     = (ratio == RATIO_W'(1));
  assign isOdd      = ratio[0] & ~isDiv1;
  assign cntNext    = (cntQ == lastIdx) ? '0 : cntQ + CNT_W'(1);

  // R3, R7: the ratio is captured during reset; the counter is parked on its
  // last index so the first edge after release wraps to 0 and drives high.
  always_ff @(posedge clkIn) begin
    if (!rstDivN) begin
      codeQ  <= cfgCode;
      cntQ   <= cfgLastIdx;
      phaseQ <= 1'b0;
      runQ   <= 1'b0;
    end else begin
      runQ   <= 1'b1;
      cntQ   <= cntNext;
      phaseQ <= (cntNext < hiLen);
    end
  end

  // R4: falling-edge copy stretches the odd-ratio high phase by half a period.
  always_ff @(negedge clkIn) begin
    if (!rstDivN) begin
      negQ <= 1'b0;
    end else begin
      negQ <= phaseQ;
    end
  end

  assign bankOut = isDiv1 ? (clkIn & runQ) : (phaseQ | (isOdd & negQ));
  // Value of the bank just before the rising edge; divide-by-1 is low there.
  assign bankLow = isDiv1 | ~(phaseQ | (isOdd & negQ));

  // R11: enables move only across a low phase of the bank.
  always_ff @(posedge clkIn) begin
    if (!rstDivN || bankLow) begin
      enQ <= want;
    end
  end

  assign outClk     = {OUTS{bankOut}} & enQ;
  assign activeCode = codeQ;
endmodule

// File: rtl/clkDivFanoutDatapath.sv
`timescale 1ns/1ps
module clkDivFanoutDatapath
  import clkDivFanoutPkg::*;
(
  input  logic                clkIn,
  input  logic                rstDivN,
  input  ctrlStrobes_t        strobes,
  output logic [NUM_OUTS-1:0] outClk,
  output logic [CODES_W-1:0]  activeCodes
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // Bank 0 takes the most significant code field.
    clkDivFanoutBank #(.OUTS(OUTS_PER_BANK)) u_bank (
      .clkIn      (clkIn),
      .rstDivN    (rstDivN),
      .cfgCode    (strobes.ratioCodes[(NUM_BANKS-1-b)*CODE_W +: CODE_W]),
      .want       (strobes.outWant[b*OUTS_PER_BANK +: OUTS_PER_BANK]),
      .outClk     (outClk[b*OUTS_PER_BANK +: OUTS_PER_BANK]),
      .activeCode (activeCodes[b*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/clkDivFanout.sv
`timescale 1ns/1ps
module clkDivFanout
  import clkDivFanoutPkg::*;
(
  input  logic                clkIn,
  input  logic                rstDivN,
  input  logic                oeGlobal,
  input  logic                loadEn,
  input  logic                serClk,
  input  logic                serData,
  output logic [NUM_OUTS-1:0] outClk
);
  ctrlStrobes_t        strobes;
  logic [NUM_OUTS-1:0] wantMask;
  logic [CODES_W-1:0]  ratioCodes;
  logic [CODES_W-1:0]  activeCodes;

  clkDivFanoutCtrl u_ctrl (
    .clkIn    (clkIn),
    .serClk   (serClk),
    .serData  (serData),
    .loadEn   (loadEn),
    .oeGlobal (oeGlobal),
    .strobes  (strobes)
  );

  clkDivFanoutDatapath u_dp (
    .clkIn       (clkIn),
    .rstDivN     (rstDivN),
    .strobes     (strobes),
    .outClk      (outClk),
    .activeCodes (activeCodes)
  );

  assign wantMask   = strobes.outWant;
  assign ratioCodes = strobes.ratioCodes;
endmodule

// File: rtl/clkDivFanoutChk.sv
`timescale 1ns/1ps
module clkDivFanoutChk
  import clkDivFanoutPkg::*;
(
  input logic                clkIn,
  input logic                rstDivN,
  input logic                loadEn,
  input logic [NUM_OUTS-1:0] wantMask,
  input logic [CODES_W-1:0]  ratioCodes,
  input logic [CODES_W-1:0]  activeCodes,
  input logic [NUM_OUTS-1:0] outClk
);
  // R3: the high phase after release shows every wanted output high.
  a_r3_common_start: assert property (@(negedge clkIn) disable iff (!rstDivN)
    $rose(rstDivN) |=> (outClk == $past(wantMask)));

  // R1: the working ratios move only after a rising load strobe.
  a_r1_load_on_rise: assert property (@(posedge clkIn) disable iff (!rstDivN)
    !$rose(loadEn) |=> $stable(ratioCodes));

  // R7: the ratio in use holds while the dividers run.
  a_r7_ratio_held: assert property (@(posedge clkIn) disable iff (!rstDivN)
    $past(rstDivN) |-> $stable(activeCodes));

  // R8: an output can start a pulse only if it was wanted.
  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_out
    a_r8_rise_needs_enable: assert property (@(negedge clkIn) disable iff (!rstDivN)
      $rose(outClk[k]) |-> $past(wantMask[k]));
  end
endmodule

bind clkDivFanout clkDivFanoutChk u_chk (
  .clkIn       (clkIn),
  .rstDivN     (rstDivN),
  .loadEn      (loadEn),
  .wantMask    (wantMask),
  .ratioCodes  (ratioCodes),
  .activeCodes (activeCodes),
  .outClk      (outClk)
);

// File: tb/clkDivFanout_tb.sv
`timescale 1ns/1ps
module clkDivFanout_tb;
  import clkDivFanoutPkg::*;

  logic clk = 1'b0, rstN = 1'b0, oe = 1'b0, le = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [NUM_OUTS-1:0] outClk;
  int checks = 0, failures = 0;
  real tE0 = 0.0;
  int curRatio [NUM_BANKS];
  logic [CFG_W-1:0] pendCfg = '0;

  clkDivFanout u_dut (
    .clkIn(clk), .rstDivN(rstN), .oeGlobal(oe), .loadEn(le),
    .serClk(sclk), .serData(sdat), .outClk(outClk)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // R2: code to ratio.
  function automatic int codeRatio(input logic [2:0] c);
    case (c)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 3; 3'd3: return 4;
      3'd4: return 5; 3'd5: return 6; 3'd6: return 8; default: return 1;
    endcase
  endfunction

  // R4: half-period h since release is high when h mod 2N < N.
  function automatic bit expBit(input int n, input int h);
    return (h % (2 * n)) < n;
  endfunction

  function automatic logic [NUM_OUTS-1:0] enMaskNow();
    return (oe && le) ? pendCfg[NUM_OUTS-1:0] : '0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive();
    @(posedge clk);
    #0.5;
  endtask

  task automatic shiftBits(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      #3 sclk = 1'b1;
      #3 sclk = 1'b0;
    end
  endtask

  // R1: optional leading junk bits must be pushed out by the word.
  task automatic loadCfg(input logic [CFG_W-1:0] w, input int extra);
    drive();
    le = 1'b0;
    if (extra > 0) shiftBits(extra, 32'h5A5A_5A5A);
    shiftBits(CFG_W, {12'd0, w});
    drive();
    le = 1'b1;
    pendCfg = w;
    repeat (2) @(posedge clk);
  endtask

  task automatic enterReset();
    drive();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic releaseReset();
    @(posedge clk);
    #1.25 check(outClk == '0, "R3", "outputs low in reset", outClk, 0);
    for (int b = 0; b < NUM_BANKS; b++)
      curRatio[b] = codeRatio(pendCfg[CFG_W-1-CODE_W*b -: CODE_W]);
    drive();
    rstN = 1'b1;
    @(posedge clk);
    tE0 = $realtime;
    #1.25 check(outClk == enMaskNow(), "R3", "all enabled high on first edge",
                outClk, enMaskNow());
  endtask

  task automatic observe(input int nSlots, input bit doCmp, input string req,
                         input logic [NUM_OUTS-1:0] expMask);
    logic [NUM_OUTS-1:0] a, b, c;
    int runLen [NUM_OUTS];
    bit seenLow [NUM_OUTS];
    int mism [NUM_OUTS];
    int firstAct [NUM_OUTS];
    int firstExp [NUM_OUTS];
    bit unstable = 1'b0, runt = 1'b0, pairBad = 1'b0;
    int runtLen = 0, runtN = 0;
    for (int k = 0; k < NUM_OUTS; k++) begin
      runLen[k] = 0; seenLow[k] = 1'b0; mism[k] = 0; firstAct[k] = 0; firstExp[k] = 0;
    end
    @(posedge clk);
    repeat (nSlots) begin
      int h;
      #0.4  a = outClk;
      #0.85 b = outClk;
      h = $rtoi(($realtime - tE0) / 2.5);
      #0.85 c = outClk;
      if (a != b || b != c) unstable = 1'b1;
      for (int k = 0; k < NUM_OUTS; k++) begin
        bit e;
        int n;
        n = curRatio[k / OUTS_PER_BANK];
        e = expMask[k] && expBit(n, h);
        if (doCmp && (b[k] != e)) begin
          if (mism[k] == 0) begin firstAct[k] = b[k]; firstExp[k] = e; end
          mism[k]++;
        end
        if (b[k]) runLen[k]++;
        else begin
          if (seenLow[k] && runLen[k] > 0 && runLen[k] != n) begin
            runt = 1'b1; runtLen = runLen[k]; runtN = n;
          end
          runLen[k] = 0;
          seenLow[k] = 1'b1;
        end
      end
      for (int p = 0; p < NUM_BANKS; p++)
        if (expMask[2*p] && expMask[2*p+1] && (b[2*p] != b[2*p+1])) pairBad = 1'b1;
      #0.4;
    end
    if (doCmp) begin
      for (int k = 0; k < NUM_OUTS; k++)
        check(mism[k] == 0, req, $sformatf("output %0d first wrong level", k),
              firstAct[k], firstExp[k]);
      check(!pairBad, "R6", "bank pair mismatch", pairBad, 0);
    end
    check(!unstable, "R5", "output changed between clock edges", unstable, 0);
    check(!runt, "R11", "high pulse length in half-periods", runtLen, runtN);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7135));
    for (int b = 0; b < NUM_BANKS; b++) curRatio[b] = 1;
    repeat (4) @(posedge clk);
    oe = 1'b1;

    // R2/R4: ratios 1,2,3,4 on banks 0..3.
    loadCfg({3'b000, 3'b001, 3'b010, 3'b011, 8'hFF}, 0);
    releaseReset();
    observe(96, 1'b1, "R4", 8'hFF);

    // R1/R2: ratios 5,6,8 and code 111, with junk bits shifted first.
    enterReset();
    loadCfg({3'b100, 3'b101, 3'b110, 3'b111, 8'hFF}, 4);
    releaseReset();
    observe(96, 1'b1, "R2", 8'hFF);

    // R8: per-output enables.
    enterReset();
    loadCfg({3'b011, 3'b010, 3'b101, 3'b001, 8'hA5}, 0);
    releaseReset();
    observe(64, 1'b1, "R8", 8'hA5);

    // R11/R9: global enable toggled mid-run, pulses must stay whole.
    fork
      observe(80, 1'b0, "R11", 8'h00);
      begin
        repeat (6) drive();
        oe = 1'b0;
        repeat (11) drive();
        oe = 1'b1;
      end
    join
    drive(); oe = 1'b0;
    observe(24, 1'b0, "R9", 8'h00);
    observe(32, 1'b1, "R9", 8'h00);
    drive(); oe = 1'b1;
    observe(24, 1'b0, "R9", 8'h00);
    observe(48, 1'b1, "R9", 8'hA5);

    // R10/R11: load strobe low mid-run.
    fork
      observe(60, 1'b0, "R11", 8'h00);
      begin
        repeat (5) drive();
        le = 1'b0;
        repeat (9) drive();
        le = 1'b1;
      end
    join
    drive(); le = 1'b0;
    observe(24, 1'b0, "R10", 8'h00);
    observe(32, 1'b1, "R10", 8'h00);

    // R7: new ratios loaded while running wait for the next release.
    loadCfg({3'b000, 3'b000, 3'b000, 3'b000, 8'hFF}, 0);
    observe(24, 1'b0, "R7", 8'h00);
    observe(64, 1'b1, "R7", 8'hFF);
    enterReset();
    releaseReset();
    observe(32, 1'b1, "R7", 8'hFF);

    // R4: random ratios and enables.
    for (int r = 0; r < 6; r++) begin
      logic [CODES_W-1:0] codes;
      logic [NUM_OUTS-1:0] en;
      codes = CODES_W'($urandom);
      en = NUM_OUTS'($urandom);
      enterReset();
      loadCfg({codes, en}, 0);
      releaseReset();
      observe(64, 1'b1, "R4", en);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule